// File: doc/BRIEF.md
# Cascadable TDM Serial Output Port

This block sends a pair of sample words (an in-phase "real" word followed by a quadrature "imaginary" word) from a receiver to a host processor over one shared serial data line. Several identical ports can hang on that same line. Each port drives the line only during its own slot, then hands the line to the next port. It does this by raising a frame-end strobe that feeds the next port's chain-start input. The downstream port begins shifting on the following serial clock. The frame ends after the last port in the chain.

A mode input selects the clocking source. As bus master the port divides the fast clock into a serial clock and issues its own frame sync whenever a fresh sample pair is waiting. As a slave it follows a serial clock and frame sync supplied by the host. Each new sample pair is copied into a holding register, so a frame already being shifted keeps its contents. A short data-valid pulse lets an edge-triggered host interrupt notice fresh samples. The pulse is 2 or 4 fast-clock cycles wide.

The controller is a three-state machine:
- `ST_IDLE`: the line is released.
- `ST_SYNC`: master only; the frame-sync output is high for one serial period.
- `ST_SHIFT`: the port owns the line.

The transitions are:
- `ST_IDLE`→`ST_SHIFT`: a start request (slave frame sync or chain start) is seen at a serial tick.
- `ST_IDLE`→`ST_SYNC`: master mode, a fresh pair is waiting, and a serial tick arrives.
- `ST_SYNC`→`ST_SHIFT`: the next serial tick.
- `ST_SHIFT`→`ST_IDLE`: the serial tick after the last bit.

Top module: `tdm_serial_port`

## Requirements
- R1: After reset, `sd_oe`, `sd_out`, `frame_end_out`, `fs_out` and `dv_out` are all low.
- R2: In slave mode (`bus_master`=0), when `fs_in` is high at a rising edge of `sclk_in`, the port drives `sd_oe` high one fast clock later and presents bit 15 (MSB) of the real word on `sd_out`.
- R3: A frame is 32 bits, one per serial rising edge, MSB first. It carries real-word bits 15..0, then imaginary-word bits 15..0. `sd_out` changes one fast clock after each serial rising edge and holds until the next one.
- R4: `frame_end_out` is high exactly while the last bit (imaginary bit 0) is driven. At the next serial rising edge, `sd_oe` and `frame_end_out` fall together. `sd_out` is low whenever `sd_oe` is low.
- R5: When `chain_start_in` is high at a serial rising edge while the port is idle, a frame starts exactly as a frame sync would, without any frame sync present.
- R6: A frame sync or chain start arriving while a frame is shifting is ignored. The frame completes unchanged and the port stays released afterwards.
- R7: A high `smp_valid` cycle copies `smp_re`/`smp_im` into the holding register. New samples arriving mid-frame do not alter the frame in progress. The next frame carries the newest pair.
- R8: `dv_out` rises on the fast clock after `smp_valid`. It stays high for 2 fast clocks when `dv_wide`=0 and for 4 when `dv_wide`=1.
- R9: In master mode (`bus_master`=1), `sclk_out` rises every `CLK_DIV` fast clocks and `fs_in` is ignored. After a fresh pair arrives, `fs_out` is high for one serial period. The frame then starts at the next `sclk_out` rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_master | input | 1 | 1 = generate serial clock and frame sync, 0 = follow host |
| dv_wide | input | 1 | Data-valid pulse width select (0: 2 cycles, 1: 4 cycles) |
| smp_valid | input | 1 | New sample pair present on smp_re/smp_im |
| smp_re | input | 16 | Real sample word |
| smp_im | input | 16 | Imaginary sample word |
| sclk_in | input | 1 | Host serial clock (slave mode) |
| fs_in | input | 1 | Host frame sync (slave mode) |
| chain_start_in | input | 1 | Frame-end strobe from the upstream port |
| sclk_out | output | 1 | Generated serial clock (master mode) |
| fs_out | output | 1 | Generated frame sync (master mode) |
| sd_out | output | 1 | Serial data |
| sd_oe | output | 1 | Drive enable for the shared data line |
| frame_end_out | output | 1 | High during the last bit; feeds the next port's chain start |
| dv_out | output | 1 | Data-valid pulse |

## Verification
The assertions assume that `sclk_in`, `fs_in` and `chain_start_in` are synchronous to `clk` and that each `sclk_in` level lasts at least one fast clock. They also assume that frame sync and chain start change only while `sclk_in` is low, that `smp_valid` pulses are at least five fast clocks apart, and that `dv_wide` holds steady across a pulse. The bench drives the host serial clock as one fast clock high and at least one low, with start inputs updated alongside the low phase. It waits six clocks after each sample load and changes `dv_wide` and `bus_master` only while the port is idle and no pulse is running.

// File: rtl/tdm_port_pkg.sv
package tdm_port_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SYNC  = 2'd1,
        ST_SHIFT = 2'd2
    } port_state_e;
endpackage

// File: rtl/tdm_sclk_tick.sv
// Serial clock source: a divider in master mode, edge detection of the
// host clock in slave mode. tick marks the fast-clock edge at which the
// serial clock rises (master) or just rose (slave).
module tdm_sclk_tick #(
    parameter int CLK_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_master,
    input  logic sclk_in,
    output logic sclk_out,
    output logic tick
);
    localparam int DIV_W = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
    localparam logic [DIV_W-1:0] LAST = DIV_W'(CLK_DIV - 1);
    localparam logic [DIV_W-1:0] HALF = DIV_W'(CLK_DIV / 2 - 1);

    logic [DIV_W-1:0] div_q;
    logic             sclk_q;
    logic             host_q;
    logic             mst_tick;
    logic             slv_tick;

    assign mst_tick = (div_q == LAST);
    assign slv_tick = sclk_in & ~host_q;
    assign tick     = bus_master ? mst_tick : slv_tick;
    assign sclk_out = sclk_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q  <= '0;
            sclk_q <= 1'b0;
            host_q <= 1'b0;
        end else begin
            host_q <= sclk_in;
            if (mst_tick) begin
                div_q  <= '0;
                sclk_q <= 1'b1;
            end else begin
                div_q <= div_q + 1'b1;
                if (div_q == HALF) begin
                    sclk_q <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/tdm_sample_hold.sv
// Holding register for the sample pair and the data-valid pulse stretcher.
module tdm_sample_hold #(
    parameter int WORD_W   = 16,
    parameter int DV_SHORT = 2,
    parameter int DV_LONG  = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  smp_valid,
    input  logic [WORD_W-1:0]     smp_re,
    input  logic [WORD_W-1:0]     smp_im,
    input  logic                  dv_wide,
    output logic [2*WORD_W-1:0]   pair,
    output logic                  dv_out
);
    localparam int DVC_W = $clog2(DV_LONG + 1);

    logic [DVC_W-1:0] dv_cnt;

    assign dv_out = (dv_cnt != '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pair   <= '0;
            dv_cnt <= '0;
        end else if (smp_valid) begin
            pair   <= {smp_re, smp_im};
            dv_cnt <= dv_wide ? DVC_W'(DV_LONG) : DVC_W'(DV_SHORT);
        end else if (dv_cnt != '0) begin
            dv_cnt <= dv_cnt - 1'b1;
        end
    end
endmodule

// File: rtl/tdm_frame_fsm.sv
// Frame controller: owns the shared line for one frame per start request.
module tdm_frame_fsm
    import tdm_port_pkg::*;
#(
    parameter int FRAME_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               bus_master,
    input  logic               fs_in,
    input  logic               chain_start_in,
    input  logic               smp_valid,
    input  logic [FRAME_W-1:0] pair,
    output logic               sd_out,
    output logic               sd_oe,
    output logic               frame_end_out,
    output logic               fs_out
);
    localparam int CNT_W = $clog2(FRAME_W);
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(FRAME_W - 1);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    port_state_e        state_q, state_d;
    logic [FRAME_W-1:0] shreg_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               oe_q, fe_q, fs_q, fresh_q;
    logic               start_req, load;

    assign start_req     = chain_start_in | (bus_master ? fs_q : fs_in);
    assign sd_oe         = oe_q;
    assign sd_out        = oe_q & shreg_q[FRAME_W-1];
    assign frame_end_out = fe_q;
    assign fs_out        = fs_q;

    // Next state
    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (tick) begin
                    if (start_req) begin
                        load    = 1'b1;
                        state_d = ST_SHIFT;
                    end else if (bus_master && fresh_q) begin
                        state_d = ST_SYNC;
                    end
                end
            end
            ST_SYNC: begin
                if (tick) begin
                    load    = 1'b1;
                    state_d = ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                if (tick && cnt_q == '0) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs and shifter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q <= '0;
            cnt_q   <= '0;
            oe_q    <= 1'b0;
            fe_q    <= 1'b0;
            fs_q    <= 1'b0;
            fresh_q <= 1'b0;
        end else begin
            if (tick) begin
                fs_q <= (state_d == ST_SYNC);
            end
            if (smp_valid) begin
                fresh_q <= 1'b1;
            end else if (load) begin
                fresh_q <= 1'b0;
            end
            if (load) begin
                shreg_q <= pair;
                cnt_q   <= CNT_TOP;
                oe_q    <= 1'b1;
                fe_q    <= (FRAME_W == 1);
            end else if (tick && state_q == ST_SHIFT) begin
                if (cnt_q == '0) begin
                    oe_q <= 1'b0;
                    fe_q <= 1'b0;
                end else begin
                    shreg_q <= shreg_q << 1;
                    cnt_q   <= cnt_q - 1'b1;
                    fe_q    <= (cnt_q == CNT_ONE);
                end
            end
        end
    end
endmodule

// File: rtl/tdm_serial_port.sv
module tdm_serial_port #(
    parameter int WORD_W   = 16,
    parameter int CLK_DIV  = 4,
    parameter int DV_SHORT = 2,
    parameter int DV_LONG  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_master,
    input  logic              dv_wide,
    input  logic              smp_valid,
    input  logic [WORD_W-1:0] smp_re,
    input  logic [WORD_W-1:0] smp_im,
    input  logic              sclk_in,
    input  logic              fs_in,
    input  logic              chain_start_in,
    output logic              sclk_out,
    output logic              fs_out,
    output logic              sd_out,
    output logic              sd_oe,
    output logic              frame_end_out,
    output logic              dv_out
);
    localparam int FRAME_W = 2 * WORD_W;

    logic               tick;
    logic [FRAME_W-1:0] pair;

    tdm_sclk_tick #(.CLK_DIV(CLK_DIV)) u_tick (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_master (bus_master),
        .sclk_in    (sclk_in),
        .sclk_out   (sclk_out),
        .tick       (tick)
    );

    tdm_sample_hold #(
        .WORD_W   (WORD_W),
        .DV_SHORT (DV_SHORT),
        .DV_LONG  (DV_LONG)
    ) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .smp_re    (smp_re),
        .smp_im    (smp_im),
        .dv_wide   (dv_wide),
        .pair      (pair),
        .dv_out    (dv_out)
    );

    tdm_frame_fsm #(.FRAME_W(FRAME_W)) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .tick           (tick),
        .bus_master     (bus_master),
        .fs_in          (fs_in),
        .chain_start_in (chain_start_in),
        .smp_valid      (smp_valid),
        .pair           (pair),
        .sd_out         (sd_out),
        .sd_oe          (sd_oe),
        .frame_end_out  (frame_end_out),
        .fs_out         (fs_out)
    );
endmodule

// File: rtl/tdm_serial_port_chk.sv
module tdm_serial_port_chk #(
    parameter int DV_SHORT = 2,
    parameter int DV_LONG  = 4
) (
    input logic clk,
    input logic rst_n,
    input logic fs_in,
    input logic chain_start_in,
    input logic fs_out,
    input logic sd_oe,
    input logic sd_out,
    input logic frame_end_out,
    input logic dv_out,
    input logic dv_wide,
    input logic smp_valid
);
    logic [7:0] dv_run;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dv_run <= '0;
        end else if (dv_out) begin
            dv_run <= dv_run + 1'b1;
        end else begin
            dv_run <= '0;
        end
    end

    // R2 / R5 / R9: the line is taken only in response to a start request
    a_r2_start_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sd_oe) |-> $past(fs_in | chain_start_in | fs_out));

    // R4: frame end only while owning the line
    a_r4_fe_owns_line: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end_out |-> sd_oe);

    // R4: the line is released only right after the last bit
    a_r4_release_after_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sd_oe) |-> $past(frame_end_out));

    // R4: released line carries zero
    a_r4_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !sd_oe |-> !sd_out);

    // R8: pulse is caused by a sample load
    a_r8_dv_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dv_out) |-> $past(smp_valid));

    // R8: pulse width follows the width select
    a_r8_dv_width: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dv_out) |-> (dv_run == (dv_wide ? 8'(DV_LONG) : 8'(DV_SHORT))));
endmodule

bind tdm_serial_port tdm_serial_port_chk #(
    .DV_SHORT (DV_SHORT),
    .DV_LONG  (DV_LONG)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .fs_in          (fs_in),
    .chain_start_in (chain_start_in),
    .fs_out         (fs_out),
    .sd_oe          (sd_oe),
    .sd_out         (sd_out),
    .frame_end_out  (frame_end_out),
    .dv_out         (dv_out),
    .dv_wide        (dv_wide),
    .smp_valid      (smp_valid)
);

// File: tb/tdm_serial_port_tb.sv
`timescale 1ns/1ps
module tdm_serial_port_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_master = 1'b0;
    logic        dv_wide = 1'b0;
    logic        smp_valid = 1'b0;
    logic [15:0] smp_re = '0;
    logic [15:0] smp_im = '0;
    logic        sclk_in = 1'b0;
    logic        fs_in = 1'b0;
    logic        chain_start_in = 1'b0;
    logic        sclk_out, fs_out, sd_out, sd_oe, frame_end_out, dv_out;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    tdm_serial_port u_dut (
        .clk(clk), .rst_n(rst_n), .bus_master(bus_master), .dv_wide(dv_wide),
        .smp_valid(smp_valid), .smp_re(smp_re), .smp_im(smp_im),
        .sclk_in(sclk_in), .fs_in(fs_in), .chain_start_in(chain_start_in),
        .sclk_out(sclk_out), .fs_out(fs_out), .sd_out(sd_out), .sd_oe(sd_oe),
        .frame_end_out(frame_end_out), .dv_out(dv_out)
    );

    localparam int NV = 4;
    localparam logic [31:0] VEC [NV] = '{
        32'h8001_7FFE, 32'hA5C3_3C5A, 32'h0000_FFFF, 32'h1234_ABCD
    };

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic load_pair(input logic [31:0] p);
        smp_re = p[31:16]; smp_im = p[15:0]; smp_valid = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic serial_cycle(output logic d, output logic oe, output logic fe);
        sclk_in = 1'b1;
        @(negedge clk);
        d = sd_out; oe = sd_oe; fe = frame_end_out;
        sclk_in = 1'b0;
        @(negedge clk);
    endtask

    // kind: 0 none, 1 fs_in during bit mid, 2 chain start during bit mid, 3 new samples after bit mid
    task automatic shift_frame(input bit via_chain, input int mid, input int kind,
                               input logic [31:0] newp, output logic [31:0] word,
                               output int bad_fe, output int bad_oe,
                               output logic rel_oe, output logic rel_fe);
        logic d, oe, fe;
        bad_fe = 0; bad_oe = 0; word = '0;
        for (int i = 0; i < 32; i++) begin
            if (i == 0) begin
                if (via_chain) chain_start_in = 1'b1; else fs_in = 1'b1;
            end
            if (i == mid && kind == 1) fs_in = 1'b1;
            if (i == mid && kind == 2) chain_start_in = 1'b1;
            serial_cycle(d, oe, fe);
            fs_in = 1'b0; chain_start_in = 1'b0;
            if (i == mid && kind == 3) load_pair(newp);
            word[31-i] = d;
            if (!oe) bad_oe++;
            if (fe !== (i == 31)) bad_fe++;
        end
        serial_cycle(d, rel_oe, rel_fe);
    endtask

    initial begin
        logic [31:0] w;
        int bfe, boe, n;
        logic roe, rfe, d, oe, fe;

        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 sd_oe", 32'(sd_oe), 0);
        check("R1 sd_out", 32'(sd_out), 0);
        check("R1 frame_end", 32'(frame_end_out), 0);
        check("R1 fs_out", 32'(fs_out), 0);
        check("R1 dv_out", 32'(dv_out), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R8: pulse width, short then long
        for (int k = 0; k < 2; k++) begin
            dv_wide = (k == 1);
            smp_re = 16'h1111; smp_im = 16'h2222; smp_valid = 1'b1;
            @(negedge clk);
            smp_valid = 1'b0;
            n = 0;
            while (dv_out && n < 10) begin n++; @(negedge clk); end
            check(k ? "R8 dv wide" : "R8 dv short", n, k ? 4 : 2);
            repeat (3) @(negedge clk);
        end
        dv_wide = 1'b0;

        // R2/R3/R4/R5: vector table, alternating frame sync and chain start
        for (int v = 0; v < NV; v++) begin
            load_pair(VEC[v]);
            shift_frame(v[0], -1, 0, '0, w, bfe, boe, roe, rfe);
            check(v[0] ? "R5 chain word" : "R3 word order", w, VEC[v]);
            check("R2 oe during frame", boe, 0);
            check("R4 frame_end on last bit only", bfe, 0);
            check("R4 release oe", 32'(roe), 0);
            check("R4 release fe", 32'(rfe), 0);
            check("R4 idle line low", 32'(sd_out), 0);
        end

        // R6: frame sync, then chain start, mid-frame are ignored
        for (int k = 1; k <= 2; k++) begin
            load_pair(32'hC0DE_0BAD);
            shift_frame(1'b0, 10, k, '0, w, bfe, boe, roe, rfe);
            check("R6 word intact", w, 32'hC0DE_0BAD);
            check("R6 frame_end intact", bfe, 0);
            check("R6 released", 32'(roe), 0);
            serial_cycle(d, oe, fe);
            check("R6 stays released", 32'(oe), 0);
        end

        // R7: new samples mid-frame do not disturb the frame
        load_pair(32'h5555_AAAA);
        shift_frame(1'b0, 8, 3, 32'h0F0F_F0F0, w, bfe, boe, roe, rfe);
        check("R7 frame keeps old pair", w, 32'h5555_AAAA);
        shift_frame(1'b0, -1, 0, '0, w, bfe, boe, roe, rfe);
        check("R7 next frame new pair", w, 32'h0F0F_F0F0);

        // R9: master mode, fs_in ignored without fresh data
        bus_master = 1'b1;
        fs_in = 1'b1;
        n = 0;
        repeat (40) begin @(negedge clk); if (sd_oe) n++; end
        fs_in = 1'b0;
        check("R9 fs_in ignored in master", n, 0);

        // R9: master frame
        begin
            logic prev;
            int bits, fs_seen, last_rise, period, fsbad, tries;
            logic [31:0] mw;
            bits = 0; fs_seen = 0; last_rise = -1; period = 0; fsbad = 0; mw = '0; bfe = 0;
            smp_re = 16'hBEEF; smp_im = 16'h1357; smp_valid = 1'b1;
            @(negedge clk);
            smp_valid = 1'b0;
            prev = sclk_out;
            tries = 0;
            while (bits < 33 && tries < 400) begin
                @(negedge clk);
                tries++;
                if (fs_out) fs_seen = 1;
                if (sclk_out && !prev) begin
                    if (last_rise >= 0) period = tries - last_rise;
                    last_rise = tries;
                    if (bits < 32 && sd_oe) begin
                        if (bits == 0 && !fs_seen) fsbad = 1;
                        mw[31-bits] = sd_out;
                        if (frame_end_out !== (bits == 31)) bfe++;
                        bits++;
                    end else if (bits == 32) begin
                        check("R9 release after master frame", 32'(sd_oe), 0);
                        bits++;
                    end
                end
                prev = sclk_out;
            end
            check("R9 master word", mw, 32'hBEEF_1357);
            check("R9 frame sync before data", fsbad, 0);
            check("R9 master frame_end", bfe, 0);
            check("R9 sclk period", period, 4);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule